// File: doc/BRIEF.md
# Configurable Command Register with Cascadable Parity

This block is the clocked address and command register that sits on a memory module between the controller and the memory devices. On each rising clock edge where a chip select is active, it captures its data inputs and drives registered copies to its outputs. When no chip select is active, the outputs keep their previous values. A two-bit mode input selects the topology at run time. In the wide topology every input lane drives one output. In the duplicated topology the low lanes drive two output banks each.

Alongside the data path, the block checks even parity over a fixed group of low-order data lanes. The parity bit used in the check is taken on the same edge as the data. A mismatch is reported on an active-low error output one cycle after the data reaches the outputs. Two devices can split the check between them. The first device forwards its partial result on a dedicated output. The second device folds that value in, in place of the ordinary parity input, and makes the final decision.

Top module: `cmd_regbuf`

## Requirements
- R1: While `rst_n` is low, all `q_main` and `q_dup` bits and `ppar_out` are 0 and `err_n` is 1. This takes effect without a clock edge.
- R2: With `mode_sel`=2'b00 (wide), a selected edge loads `q_main` with `d_in` (all 25 lanes) and clears `q_dup`.
- R3: With `mode_sel` set to 2'b01 (first of pair), 2'b10 (second of pair) or 2'b11 (duplicated, standalone), a selected edge loads `q_main[13:0]` and `q_dup[13:0]` both with `d_in[13:0]`, and clears `q_main[24:14]`.
- R4: An edge is selected when at least one bit of `cs_n` is 0. On an edge with `cs_n`=2'b11, `q_main` and `q_dup` keep their values.
- R5: In modes 2'b00 and 2'b11, after the edge that follows a selected edge, `err_n` is 0 exactly when the XOR of the checked lanes and `par_in` captured on the selected edge is 1. The checked lanes are `d_in[21:0]` in wide mode and `d_in[10:0]` in the duplicated modes.
- R6: In mode 2'b01, a selected edge sets `ppar_out` to the XOR of `d_in[10:0]` and `par_in`. In this mode `err_n` is never driven low.
- R7: In mode 2'b10, the check of R5 uses `ppar_in` in place of `par_in`, and `par_in` has no effect on `err_n`.
- R8: An unselected edge produces no error: on the edge after it, `err_n` returns to 1.
- R9: In any mode other than 2'b01, and on unselected edges, `ppar_out` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge capture clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Topology and cascade role |
| cs_n | input | 2 | Chip selects, active low; either one enables capture |
| d_in | input | 25 | Data lanes |
| par_in | input | 1 | Even-parity bit from the controller |
| ppar_in | input | 1 | Partial parity from the first device of a pair |
| q_main | output | 25 | Registered primary outputs |
| q_dup | output | 14 | Registered duplicate outputs |
| ppar_out | output | 1 | Partial parity to the second device of a pair |
| err_n | output | 1 | Parity error, 0 = error, 1 = released |

## Verification
The error flag for one capture is updated on the same edge on which the next capture loads the outputs or holds them. A wrong flag can therefore hide behind correct data. The bench provokes this by following a corrupted-parity capture directly with an unselected edge that also carries bad parity. It then checks, on the same sample, that the outputs still hold the earlier data and that `err_n` is low for the first capture only. On the following edge the bench checks that `err_n` has been released.

// File: rtl/cmd_regbuf_pkg.sv
package cmd_regbuf_pkg;

  localparam int MAXW = 32;

  typedef enum logic [1:0] {
    MODE_WIDE     = 2'b00,
    MODE_DUP_A    = 2'b01,
    MODE_DUP_B    = 2'b10,
    MODE_DUP_SOLO = 2'b11
  } mode_e;

  // XOR of the lowest n bits of v
  function automatic logic low_xor(input logic [MAXW-1:0] v, input int n);
    logic r;
    r = 1'b0;
    for (int i = 0; i < MAXW; i++) begin
      if (i < n) r = r ^ v[i];
    end
    return r;
  endfunction

endpackage

// File: rtl/cmd_regbuf_cfg.sv
module cmd_regbuf_cfg
  import cmd_regbuf_pkg::*;
(
  input  logic [1:0] mode_sel,
  output logic       is_wide,
  output logic       is_a,
  output logic       is_b
);

  mode_e mode;

  always_comb begin
    mode    = mode_e'(mode_sel);
    is_wide = (mode == MODE_WIDE);
    is_a    = (mode == MODE_DUP_A);
    is_b    = (mode == MODE_DUP_B);
  end

endmodule

// File: rtl/cmd_regbuf_lanes.sv
module cmd_regbuf_lanes #(
  parameter int N_WIDE = 25,
  parameter int N_DUP  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              is_wide,
  input  logic [N_WIDE-1:0] d,
  output logic [N_WIDE-1:0] q_main,
  output logic [N_DUP-1:0]  q_dup
);

  localparam int N_HIGH = N_WIDE - N_DUP;

  for (genvar i = 0; i < N_WIDE; i++) begin : g_main
    if (i < N_DUP) begin : g_low
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q_main[i] <= 1'b0;
        else if (sel) q_main[i] <= d[i];
      end
    end else begin : g_high
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q_main[i] <= 1'b0;
        else if (sel) q_main[i] <= is_wide ? d[i] : 1'b0;
      end
    end
  end

  for (genvar j = 0; j < N_DUP; j++) begin : g_dup
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q_dup[j] <= 1'b0;
      else if (sel) q_dup[j] <= is_wide ? 1'b0 : d[j];
    end
  end

  a_r2_dup_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && is_wide) |=> (q_dup == '0));

  a_r3_upper_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !is_wide) |=> (q_main[N_WIDE-1 -: N_HIGH] == '0));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(q_main) && $stable(q_dup)));

endmodule

// File: rtl/cmd_regbuf_parity.sv
module cmd_regbuf_parity
  import cmd_regbuf_pkg::*;
#(
  parameter int N_WIDE    = 25,
  parameter int CHK_WIDE  = 22,
  parameter int CHK_DUP   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              is_wide,
  input  logic              is_a,
  input  logic              is_b,
  input  logic [N_WIDE-1:0] d,
  input  logic              par_in,
  input  logic              ppar_in,
  output logic              ppar_out,
  output logic              err_n
);

  logic own_wide, own_dup, own_sel, seed, mismatch, fail_q;

  always_comb begin
    own_wide = low_xor(MAXW'(d), CHK_WIDE);
    own_dup  = low_xor(MAXW'(d), CHK_DUP);
    own_sel  = is_wide ? own_wide : own_dup;
    seed     = is_b ? ppar_in : par_in;
    mismatch = own_sel ^ seed;
  end

  // stage 1: captured with the data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppar_out <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      ppar_out <= sel & is_a & (own_dup ^ par_in);
      fail_q   <= sel & ~is_a & mismatch;
    end
  end

  // stage 2: error flag one cycle behind the data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_n <= 1'b1;
    else        err_n <= ~fail_q;
  end

  a_r5_flag_error: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !is_a && mismatch) |=> ##1 !err_n);

  a_r6_first_released: assert property (@(posedge clk) disable iff (!rst_n)
    is_a |=> ##1 err_n);

  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ##1 err_n);

  a_r9_ppar_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_a || !sel) |=> !ppar_out);

endmodule

// File: rtl/cmd_regbuf.sv
module cmd_regbuf #(
  parameter int N_WIDE   = 25,
  parameter int N_DUP    = 14,
  parameter int CHK_WIDE = 22,
  parameter int CHK_DUP  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic [1:0]        cs_n,
  input  logic [N_WIDE-1:0] d_in,
  input  logic              par_in,
  input  logic              ppar_in,
  output logic [N_WIDE-1:0] q_main,
  output logic [N_DUP-1:0]  q_dup,
  output logic              ppar_out,
  output logic              err_n
);

  logic sel, is_wide, is_a, is_b;

  assign sel = ~&cs_n;

  cmd_regbuf_cfg u_cfg (
    .mode_sel (mode_sel),
    .is_wide  (is_wide),
    .is_a     (is_a),
    .is_b     (is_b)
  );

  cmd_regbuf_lanes #(.N_WIDE(N_WIDE), .N_DUP(N_DUP)) u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .is_wide (is_wide),
    .d       (d_in),
    .q_main  (q_main),
    .q_dup   (q_dup)
  );

  cmd_regbuf_parity #(.N_WIDE(N_WIDE), .CHK_WIDE(CHK_WIDE), .CHK_DUP(CHK_DUP)) u_par (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .is_wide  (is_wide),
    .is_a     (is_a),
    .is_b     (is_b),
    .d        (d_in),
    .par_in   (par_in),
    .ppar_in  (ppar_in),
    .ppar_out (ppar_out),
    .err_n    (err_n)
  );

endmodule

// File: tb/cmd_regbuf_tb_top.sv
module cmd_regbuf_tb_top;

  localparam logic [1:0] M_WIDE = 2'b00, M_A = 2'b01, M_B = 2'b10, M_SOLO = 2'b11;
  localparam logic [1:0] CS_ON = 2'b10, CS_OFF = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = M_WIDE;
  logic [1:0]  cs_n = CS_OFF;
  logic [24:0] d_in = '0;
  logic        par_in = 1'b0, ppar_in = 1'b0;
  logic [24:0] q_main;
  logic [13:0] q_dup;
  logic        ppar_out, err_n;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  cmd_regbuf dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
    .d_in(d_in), .par_in(par_in), .ppar_in(ppar_in),
    .q_main(q_main), .q_dup(q_dup), .ppar_out(ppar_out), .err_n(err_n)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [24:0] d, input logic p, input logic pp, input logic [1:0] cs);
    d_in = d; par_in = p; ppar_in = pp; cs_n = cs;
    @(posedge clk); #1;
  endtask

  function automatic logic odd_of(input logic [24:0] d, input int n);
    logic [24:0] m;
    m = (25'd1 << n) - 25'd1;
    return ^(d & m);
  endfunction

  task automatic t_reset();
    chk("R1 q_main", q_main, 0);
    chk("R1 q_dup", q_dup, 0);
    chk("R1 err_n", err_n, 1);
    chk("R1 ppar_out", ppar_out, 0);
    mode_sel = M_A;
    drive(25'h1ffffff, 1'b0, 1'b0, CS_ON);
    drive(25'h0, 1'b0, 1'b0, CS_OFF);
    mode_sel = M_WIDE;
    drive(25'h1ffffff, 1'b0, 1'b0, CS_ON); // 22 ones + 0 -> even, ok
    #1 rst_n = 1'b0; #1;
    chk("R1 async q_main", q_main, 0);
    chk("R1 async ppar", ppar_out, 0);
    chk("R1 async err_n", err_n, 1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic t_wide();
    mode_sel = M_WIDE;
    for (int k = 0; k < 6; k++) begin
      logic [24:0] d;
      logic p;
      d = 25'($urandom);
      p = odd_of(d, 22) ^ k[0]; // odd k -> corrupted
      drive(d, p, $urandom % 2 == 1, (k == 2) ? 2'b01 : CS_ON);
      chk("R2 q_main", q_main, d);
      chk("R2 q_dup", q_dup, 0);
      drive(~d, ~p, 1'b0, CS_OFF);
      chk("R4 hold", q_main, d);
      chk("R5 wide err_n", err_n, !k[0]);
    end
  endtask

  task automatic t_solo();
    mode_sel = M_SOLO;
    for (int k = 0; k < 6; k++) begin
      logic [24:0] d;
      logic p;
      d = 25'($urandom) | 25'h1ff0000;
      p = odd_of(d, 11) ^ (k == 1 || k == 4);
      drive(d, p, 1'b1, CS_ON);
      chk("R3 q_main", q_main, {11'b0, d[13:0]});
      chk("R3 q_dup", q_dup, d[13:0]);
      drive(d, p, 1'b0, CS_OFF);
      chk("R4 dup hold", q_dup, d[13:0]);
      chk("R5 dup err_n", err_n, !(k == 1 || k == 4));
    end
  endtask

  task automatic t_first();
    mode_sel = M_A;
    for (int k = 0; k < 5; k++) begin
      logic [24:0] d;
      logic p;
      d = 25'($urandom);
      p = k[0];
      drive(d, p, 1'b0, CS_ON);
      chk("R6 ppar_out", ppar_out, odd_of(d, 11) ^ p);
      chk("R3 first q_dup", q_dup, d[13:0]);
      drive(d, ~p, 1'b0, CS_OFF);
      chk("R6 err released", err_n, 1);
      chk("R9 ppar idle", ppar_out, 0);
    end
  endtask

  task automatic t_second();
    mode_sel = M_B;
    for (int k = 0; k < 6; k++) begin
      logic [24:0] d;
      logic pp;
      d = 25'($urandom);
      pp = odd_of(d, 11) ^ (k >= 3);
      drive(d, $urandom % 2 == 1, pp, CS_ON);
      chk("R9 ppar in B", ppar_out, 0);
      chk("R3 second q_main", q_main, {11'b0, d[13:0]});
      drive(d, 1'b0, 1'b0, CS_OFF);
      chk("R7 err from ppar_in", err_n, !(k >= 3));
    end
  endtask

  task automatic t_idle_overlap();
    logic [24:0] d0, d1;
    mode_sel = M_WIDE;
    d0 = 25'h0a5a5a5;
    d1 = 25'h1234567;
    drive(d0, ~odd_of(d0, 22), 1'b0, CS_ON);       // bad parity, selected
    drive(d1, ~odd_of(d1, 22), 1'b0, CS_OFF);      // bad parity, unselected
    chk("R4 hold during flag", q_main, d0);
    chk("R5 flag of selected", err_n, 0);
    drive(d1, 1'b0, 1'b0, CS_OFF);
    chk("R8 idle edge no error", err_n, 1);
    chk("R9 wide ppar", ppar_out, 0);
  endtask

  initial begin
    #(8 * 20000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_wide();
    t_solo();
    t_first();
    t_second();
    t_idle_overlap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule